// File: doc/BRIEF.md
# Audio controller interrupt aggregator

This block gathers the interrupt sources of an audio controller into one 32-bit interrupt status word and turns that word into the controller's interrupt signalling. The sources are the per-stream buffer-completion flags, the response-ring interrupt and overrun flags, and the codec state-change status masked by the wake-enable mask. An interrupt control word enables each source and also carries a master enable.

The status word is not free-running. It is recomputed from the live sources only when the surrounding register logic pulses `recalc_i`. That logic raises the pulse whenever one of these is written: the wake-enable mask, the codec state status, the interrupt control word, the ring status, or any stream control word. Between recomputes the word holds its value. Software can clear the summary bits and the stream bits by writing ones to them.

The level output is the AND of the global pending bit and the master enable. When message signalling is both supported (`msg_cap_i`) and enabled (`msg_en_i`), the level line stays low. Instead, one single-cycle pulse is sent for each rising edge of the computed level.

Top module: `irq_aggregator`

## Requirements
- R1: On a recompute, status bit i (0 to NSTREAM-1) equals `stream_bc_i[i]`. Input streams use slots 0 to 3 and output streams use slots 4 to 7.
- R2: On a recompute, status bit 30 is 1 exactly when `ring_irq_i` is 1, or `ring_ovr_i` is 1, or `codec_sts_i & wake_en_i` is nonzero.
- R3: On a recompute, status bit 31 is 1 exactly when status bits 30:0 ANDed with `int_ctl_i[30:0]` is nonzero.
- R4: Without `recalc_i` and without a clear write, the status word keeps its value, whatever the sources do.
- R5: A cycle with `clr_we_i` clears each status bit whose position is set in `clr_data_i & 0xC00000FF`. Bits written with 0 keep their value.
- R6: When `recalc_i` and `clr_we_i` fall in the same cycle, the clear is applied to the freshly recomputed word.
- R7: When not in message mode, `irq_level_o` equals status bit 31 AND `int_ctl_i[31]`.
- R8: In message mode (`msg_cap_i` and `msg_en_i` both 1), `irq_level_o` is 0. `msg_pulse_o` is high for exactly one cycle after a rising edge of the computed level.
- R9: A computed level that stays high sends no further pulse, and with `msg_cap_i`=1 but `msg_en_i`=0 the block uses the level line.
- R10: After reset, the status word, `irq_level_o` and `msg_pulse_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recalc_i | input | 1 | Recompute strobe from the register logic |
| clr_we_i | input | 1 | Write-one-to-clear strobe for the status word |
| clr_data_i | input | 32 | Write data for the clear |
| ring_irq_i | input | 1 | Response-ring interrupt flag |
| ring_ovr_i | input | 1 | Response-ring overrun flag |
| codec_sts_i | input | NCODEC | Codec state-change status |
| wake_en_i | input | NCODEC | Wake-enable mask |
| stream_bc_i | input | NSTREAM | Buffer-completion flags, one per stream |
| int_ctl_i | input | 32 | Interrupt control word (bit 31 is the master enable) |
| msg_cap_i | input | 1 | Message signalling is supported |
| msg_en_i | input | 1 | Message signalling is enabled |
| int_sts_o | output | 32 | Interrupt status word |
| irq_level_o | output | 1 | Level interrupt output |
| msg_pulse_o | output | 1 | Single-cycle message notification |

## Verification
A recompute or clear strobe driven in one cycle changes `int_sts_o` at the next rising edge. The level output and the message pulse follow that edge combinationally and need no further register. The bench therefore drives every strobe at a falling edge, removes it at the next falling edge, and samples all three results at that same falling edge, one clock after the stimulus. The message pulse is sampled once more a cycle later to confirm that it lasted only one cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int STS_W    = 32;
  localparam int GLB_BIT  = 31;
  localparam int CTRL_BIT = 30;
endpackage

// File: rtl/irq_src_gather.sv
module irq_src_gather
  import irq_agg_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic [NSTREAM-1:0] stream_bc_i,
  input  logic               ring_irq_i,
  input  logic               ring_ovr_i,
  input  logic [NCODEC-1:0]  codec_sts_i,
  input  logic [NCODEC-1:0]  wake_en_i,
  input  logic [STS_W-2:0]   ctl_en_i,
  output logic [STS_W-1:0]   cand_o
);
  logic [STS_W-2:0] srcs;

  // stream slots: one bit per stream, input streams first
  for (genvar s = 0; s < CTRL_BIT; s++) begin : g_slot
    if (s < NSTREAM) begin : g_str
      assign srcs[s] = stream_bc_i[s];
    end else begin : g_nil
      assign srcs[s] = 1'b0;
    end
  end

  assign srcs[CTRL_BIT] = ring_irq_i | ring_ovr_i | (|(codec_sts_i & wake_en_i));

  assign cand_o = {|(srcs & ctl_en_i), srcs};
endmodule

// File: rtl/irq_sts_reg.sv
module irq_sts_reg
  import irq_agg_pkg::*;
#(
  parameter logic [STS_W-1:0] CLR_MASK = 32'hC00000FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recalc_i,
  input  logic [STS_W-1:0] cand_i,
  input  logic             clr_we_i,
  input  logic [STS_W-1:0] clr_data_i,
  output logic [STS_W-1:0] sts_o
);
  logic [STS_W-1:0] base, clr_bits;

  always_comb begin
    base     = recalc_i ? cand_i : sts_o;
    clr_bits = clr_we_i ? (clr_data_i & CLR_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_o <= '0;
    else        sts_o <= base & ~clr_bits;
  end

  // R4
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!recalc_i && !clr_we_i) |=> $stable(sts_o));

  // R5
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((sts_o & $past(clr_data_i & CLR_MASK)) == '0));

  // R5
  clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !recalc_i) |=> ((sts_o & ~$past(clr_data_i & CLR_MASK)) ==
                                 ($past(sts_o) & ~$past(clr_data_i & CLR_MASK))));
endmodule

// File: rtl/irq_signal_out.sv
module irq_signal_out (
  input  logic clk,
  input  logic rst_n,
  input  logic glb_pend_i,
  input  logic master_en_i,
  input  logic msg_cap_i,
  input  logic msg_en_i,
  output logic irq_level_o,
  output logic msg_pulse_o
);
  logic lvl, lvl_prev, msg_mode;

  assign lvl      = glb_pend_i & master_en_i;
  assign msg_mode = msg_cap_i & msg_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  assign irq_level_o = lvl & ~msg_mode;
  assign msg_pulse_o = msg_mode & lvl & ~lvl_prev;

  // R8
  msg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_cap_i && msg_en_i) |-> !irq_level_o);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse_o |=> !msg_pulse_o);

  // R7
  level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level_o |-> (glb_pend_i && master_en_i));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               recalc_i,
  input  logic               clr_we_i,
  input  logic [31:0]        clr_data_i,
  input  logic               ring_irq_i,
  input  logic               ring_ovr_i,
  input  logic [NCODEC-1:0]  codec_sts_i,
  input  logic [NCODEC-1:0]  wake_en_i,
  input  logic [NSTREAM-1:0] stream_bc_i,
  input  logic [31:0]        int_ctl_i,
  input  logic               msg_cap_i,
  input  logic               msg_en_i,
  output logic [31:0]        int_sts_o,
  output logic               irq_level_o,
  output logic               msg_pulse_o
);
  localparam logic [STS_W-1:0] CLR_MASK =
    {2'b11, {(CTRL_BIT-NSTREAM){1'b0}}, {NSTREAM{1'b1}}};

  logic [STS_W-1:0] cand;

  irq_src_gather #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) u_gather (
    .stream_bc_i (stream_bc_i),
    .ring_irq_i  (ring_irq_i),
    .ring_ovr_i  (ring_ovr_i),
    .codec_sts_i (codec_sts_i),
    .wake_en_i   (wake_en_i),
    .ctl_en_i    (int_ctl_i[STS_W-2:0]),
    .cand_o      (cand)
  );

  irq_sts_reg #(.CLR_MASK(CLR_MASK)) u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .recalc_i   (recalc_i),
    .cand_i     (cand),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .sts_o      (int_sts_o)
  );

  irq_signal_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_pend_i  (int_sts_o[GLB_BIT]),
    .master_en_i (int_ctl_i[GLB_BIT]),
    .msg_cap_i   (msg_cap_i),
    .msg_en_i    (msg_en_i),
    .irq_level_o (irq_level_o),
    .msg_pulse_o (msg_pulse_o)
  );

  // R3
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc_i && !clr_we_i && int_ctl_i[30:0] == '0) |=> !int_sts_o[GLB_BIT]);

  // R1
  stream_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc_i && !clr_we_i) |=> (int_sts_o[NSTREAM-1:0] == $past(stream_bc_i)));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        recalc = 1'b0, clr_we = 1'b0;
  logic [31:0] clr_data = '0;
  logic        ring_irq = 1'b0, ring_ovr = 1'b0;
  logic [14:0] codec_sts = '0, wake_en = '0;
  logic [7:0]  stream_bc = '0;
  logic [31:0] int_ctl = '0;
  logic        msg_cap = 1'b0, msg_en = 1'b0;
  logic [31:0] int_sts;
  logic        irq_level, msg_pulse;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .recalc_i(recalc), .clr_we_i(clr_we),
    .clr_data_i(clr_data), .ring_irq_i(ring_irq), .ring_ovr_i(ring_ovr),
    .codec_sts_i(codec_sts), .wake_en_i(wake_en), .stream_bc_i(stream_bc),
    .int_ctl_i(int_ctl), .msg_cap_i(msg_cap), .msg_en_i(msg_en),
    .int_sts_o(int_sts), .irq_level_o(irq_level), .msg_pulse_o(msg_pulse)
  );

  typedef struct packed {
    logic [7:0]  st;
    logic        ri;
    logic        ro;
    logic [14:0] cs;
    logic [14:0] we;
    logic [31:0] ctl;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{8'h01, 1'b0, 1'b0, 15'h0000, 15'h0000, 32'h8000_0001, 32'h8000_0001},
    '{8'h90, 1'b0, 1'b0, 15'h0000, 15'h0000, 32'h8000_0010, 32'h8000_0090},
    '{8'h00, 1'b1, 1'b0, 15'h0000, 15'h0000, 32'h4000_0000, 32'hC000_0000},
    '{8'h00, 1'b0, 1'b1, 15'h0000, 15'h0000, 32'h0000_00FF, 32'h4000_0000},
    '{8'h00, 1'b0, 1'b0, 15'h0004, 15'h0004, 32'hC000_0000, 32'hC000_0000},
    '{8'h00, 1'b0, 1'b0, 15'h0004, 15'h0002, 32'hC000_00FF, 32'h0000_0000},
    '{8'hFF, 1'b0, 1'b0, 15'h0000, 15'h0000, 32'h8000_0080, 32'h8000_00FF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    recalc   = 1'b0;
    clr_we   = 1'b0;
    clr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sts", int_sts, 32'h0);
    chk("R10 level", {31'b0, irq_level}, 32'h0);
    chk("R10 pulse", {31'b0, msg_pulse}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R7 table walk
    foreach (TBL[i]) begin
      stream_bc = TBL[i].st; ring_irq = TBL[i].ri; ring_ovr = TBL[i].ro;
      codec_sts = TBL[i].cs; wake_en = TBL[i].we; int_ctl = TBL[i].ctl;
      recalc = 1'b1;
      strobe();
      chk($sformatf("R1/R2/R3 vec%0d sts", i), int_sts, TBL[i].exp);
      chk($sformatf("R7 vec%0d level", i), {31'b0, irq_level},
          {31'b0, TBL[i].exp[31] & TBL[i].ctl[31]});
    end

    // R4 sources change without recompute: word held at 0x800000FF
    stream_bc = 8'h00; ring_irq = 1'b1; int_ctl = 32'h4000_0080;
    repeat (2) @(negedge clk);
    chk("R4 held", int_sts, 32'h8000_00FF);
    ring_irq = 1'b0; stream_bc = 8'hFF; int_ctl = 32'h8000_0080;

    // R5 clear low nibble
    clr_we = 1'b1; clr_data = 32'h0000_000F;
    strobe();
    chk("R5 partial clear", int_sts, 32'h8000_00F0);
    // R5 mask keeps bits 29:8 from acting; bit 31 cleared
    clr_we = 1'b1; clr_data = 32'hFFFF_FF00;
    strobe();
    chk("R5 high clear", int_sts, 32'h0000_00F0);
    chk("R5 level after clear", {31'b0, irq_level}, 32'h0);

    // R6 recompute and clear together
    recalc = 1'b1; clr_we = 1'b1; clr_data = 32'h0000_0001;
    strobe();
    chk("R6 same cycle", int_sts, 32'h8000_00FE);

    // R8 message mode
    msg_cap = 1'b1; msg_en = 1'b1;
    stream_bc = 8'h00; int_ctl = 32'h8000_0001;
    recalc = 1'b1;
    strobe();
    chk("R8 idle pulse", {31'b0, msg_pulse}, 32'h0);
    stream_bc = 8'h01;
    recalc = 1'b1;
    strobe();
    chk("R8 pulse", {31'b0, msg_pulse}, 32'h1);
    chk("R8 level quiet", {31'b0, irq_level}, 32'h0);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, msg_pulse}, 32'h0);
    // R9 held level, recompute again: no second pulse
    recalc = 1'b1;
    strobe();
    chk("R9 no resend", {31'b0, msg_pulse}, 32'h0);
    // R9 supported but disabled: level line used
    msg_en = 1'b0;
    @(negedge clk);
    chk("R9 level mode", {31'b0, irq_level}, 32'h1);
    chk("R9 no pulse in level mode", {31'b0, msg_pulse}, 32'h0);

    finish_run();
  end
endmodule